// File: doc/BRIEF.md
# Receive Resource Ring Fetcher

This block keeps the read side of a circular table of receive-buffer entries that lives in system memory. Each entry is four 16-bit fields that together name one receive buffer: where it starts and how many 16-bit words it holds. When a fetch is requested, the block reads the entry at the current read pointer one field at a time through a word-wide memory read port. It then loads the current buffer address and the remaining-word count, and moves the read pointer to the next entry. The pointer wraps from the ring end back to the ring start. The block flags that the ring has run dry when the read pointer lands on the write pointer kept by software.

Software sets the ring start, ring end, read pointer, write pointer, the upper address segment and a low-water word threshold through a small write port. A fetch can be started in three ways: by an explicit command, by software clearing the exhausted flag, or by the receive path reporting a finished packet that leaves fewer words in the current buffer than the threshold. A data-width mode selects 16-bit or 32-bit slots for the fields. This changes the field stride and the size of one entry.

Top module: `rx_ring_fetch`

## Requirements
- R1: After reset, busy, fetch_done, exhausted and mem_valid are 0, and rd_ptr, buf_addr and buf_words are 0.
- R2: A write with reg_wr_en selects a register through reg_wr_sel: 0 ring start, 1 ring end, 2 read pointer, 3 write pointer, 4 address segment, 5 low-water threshold. Bit 0 of the four pointers is always stored as 0. A write to the read pointer shows on rd_ptr in the next cycle.
- R3: While idle, a fetch starts at the clock edge where cmd_fetch is high, or exh_clr is high while exhausted is 1, or pkt_done raises a low-water request (R10). busy is 1 from the next cycle.
- R4: While busy, cmd_fetch, pkt_done and the start effect of exh_clr are ignored. Each started fetch advances the read pointer exactly once.
- R5: A fetch reads four fields in order: address low, address high, word count low, word count high. Field i is read from address {segment, read pointer + i*S}, where S is 2 with cfg_wide=0 and 4 with cfg_wide=1. The segment and read pointer are the values held when the fetch started. Sums wrap within 16 bits. Only the 16-bit mem_rdata is used.
- R6: mem_valid stays high with a stable mem_addr until mem_ready is seen. After that, the next field is requested only after a mem_rvalid cycle.
- R7: At the edge that takes the fourth field, buf_addr becomes {field1, field0}, buf_words becomes {field3, field2}, and busy falls. fetch_done is high for exactly the following cycle.
- R8: At completion the read pointer becomes the start pointer plus 8 (cfg_wide=0) or 16 (cfg_wide=1), modulo 2^16. If that value equals the ring end, the read pointer is set to the ring start instead.
- R9: exhausted is set at completion when the new read pointer equals the write pointer. It is cleared by exh_clr. If both happen at the same edge, the set wins.
- R10: pkt_done while idle subtracts pkt_words from buf_words (32-bit wrap). If the unsigned result is below the zero-extended threshold, a fetch starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wide | input | 1 | 1 selects 32-bit field slots, 0 selects 16-bit; change only while idle |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 3 | Register select (codes in R2) |
| reg_wr_data | input | 16 | Register write data |
| cmd_fetch | input | 1 | Fetch command |
| exh_clr | input | 1 | Clear the exhausted flag; starts a fetch if it was set |
| pkt_done | input | 1 | A received packet consumed pkt_words words |
| pkt_words | input | 32 | Words consumed by the finished packet |
| mem_valid | output | 1 | Read request valid |
| mem_ready | input | 1 | Read request accepted |
| mem_addr | output | 32 | Read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |
| busy | output | 1 | Fetch in progress |
| fetch_done | output | 1 | One-cycle pulse after a fetch completes |
| exhausted | output | 1 | Ring exhausted flag |
| rd_ptr | output | 16 | Current read pointer |
| buf_addr | output | 32 | Current buffer address |
| buf_words | output | 32 | Remaining words in the current buffer |

## Verification
The fetch is driven with a memory whose ready and response latency vary from cycle to cycle. This separates a sequencer that waits on each handshake from one that assumes a fixed latency. The narrow ring is walked until the read pointer meets the write pointer and then wraps past the end. This tells the exhaustion compare apart from the wrap compare. Low-water requests are tried with a remainder exactly at the threshold and one word below it, which exposes an off-by-one in the compare. Repeated requests during a fetch and a switch to wide mode check that only one advance happens per fetch and that both the stride and the entry size follow the mode.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
  parameter int RRF_PW = 16;
  localparam int RRF_FIELDS = 4;
  localparam int RRF_IDX_W = $clog2(RRF_FIELDS);
  localparam int RRF_AW = 2 * RRF_PW;

  typedef logic [RRF_PW-1:0] ptr_t;
  typedef logic [RRF_AW-1:0] wide_t;
  typedef enum logic [1:0] {FS_IDLE, FS_ISSUE, FS_WAIT} fetch_state_t;

  localparam logic [2:0] SEL_START = 3'd0;
  localparam logic [2:0] SEL_END   = 3'd1;
  localparam logic [2:0] SEL_RD    = 3'd2;
  localparam logic [2:0] SEL_WR    = 3'd3;
  localparam logic [2:0] SEL_SEG   = 3'd4;
  localparam logic [2:0] SEL_THR   = 3'd5;

  function automatic ptr_t even_ptr(ptr_t d);
    return {d[RRF_PW-1:1], 1'b0};
  endfunction

  function automatic ptr_t field_offset(logic [RRF_IDX_W-1:0] idx, logic wide);
    return ptr_t'(idx) << (wide ? 2 : 1);
  endfunction

  function automatic ptr_t entry_bytes(logic wide);
    return ptr_t'(RRF_FIELDS * (wide ? 4 : 2));
  endfunction

  function automatic ptr_t ptr_advance(ptr_t base, ptr_t ring_end, ptr_t ring_start, logic wide);
    ptr_t nxt;
    nxt = base + entry_bytes(wide);
    return (nxt == ring_end) ? ring_start : nxt;
  endfunction

  function automatic logic below_water(wide_t words, ptr_t thr);
    return words < {{RRF_PW{1'b0}}, thr};
  endfunction
endpackage

// File: rtl/rrf_regs.sv
module rrf_regs
  import rrf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  ptr_t        wr_data,
  output ptr_t        ring_start,
  output ptr_t        ring_end,
  output ptr_t        wr_ptr,
  output ptr_t        seg,
  output ptr_t        low_thr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_start <= '0;
      ring_end   <= '0;
      wr_ptr     <= '0;
      seg        <= '0;
      low_thr    <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_START: ring_start <= even_ptr(wr_data);
        SEL_END:   ring_end   <= even_ptr(wr_data);
        SEL_WR:    wr_ptr     <= even_ptr(wr_data);
        SEL_SEG:   seg        <= wr_data;
        SEL_THR:   low_thr    <= wr_data;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rrf_ptr_unit.sv
module rrf_ptr_unit
  import rrf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wide,
  input  logic rd_wr,
  input  ptr_t rd_wr_data,
  input  logic fetch_last,
  input  ptr_t base_ptr,
  input  ptr_t ring_start,
  input  ptr_t ring_end,
  input  ptr_t wr_ptr,
  input  logic exh_clr,
  output ptr_t rd_ptr,
  output logic exhausted,
  output ptr_t adv_ptr,
  output logic adv_hits_wr
);
  assign adv_ptr     = ptr_advance(base_ptr, ring_end, ring_start, wide);
  assign adv_hits_wr = (adv_ptr == wr_ptr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr    <= '0;
      exhausted <= 1'b0;
    end else begin
      if (fetch_last)  rd_ptr <= adv_ptr;
      else if (rd_wr)  rd_ptr <= rd_wr_data;
      if (fetch_last && adv_hits_wr) exhausted <= 1'b1;
      else if (exh_clr)              exhausted <= 1'b0;
    end
  end
endmodule

// File: rtl/rrf_fetch_seq.sv
module rrf_fetch_seq
  import rrf_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wide,
  input  logic                          start_req,
  input  ptr_t                          rd_ptr,
  input  ptr_t                          seg,
  input  logic                          mem_ready,
  input  logic                          mem_rvalid,
  input  ptr_t                          mem_rdata,
  output logic                          busy,
  output logic                          mem_valid,
  output wide_t                         mem_addr,
  output logic                          fetch_last,
  output ptr_t                          base_ptr,
  output logic [RRF_FIELDS-1:0][RRF_PW-1:0] entry,
  output logic                          done_q
);
  localparam logic [RRF_IDX_W-1:0] LAST_IDX = RRF_IDX_W'(RRF_FIELDS - 1);

  fetch_state_t           state;
  logic [RRF_IDX_W-1:0]   idx;
  ptr_t                   seg_q;
  ptr_t                   fld [RRF_FIELDS-1];

  assign busy       = (state != FS_IDLE);
  assign mem_valid  = (state == FS_ISSUE);
  assign mem_addr   = {seg_q, base_ptr + field_offset(idx, wide)};
  assign fetch_last = (state == FS_WAIT) && mem_rvalid && (idx == LAST_IDX);

  for (genvar g = 0; g < RRF_FIELDS - 1; g++) begin : g_entry
    assign entry[g] = fld[g];
  end
  assign entry[RRF_FIELDS-1] = mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= FS_IDLE;
      idx      <= '0;
      seg_q    <= '0;
      base_ptr <= '0;
      done_q   <= 1'b0;
      for (int i = 0; i < RRF_FIELDS - 1; i++) fld[i] <= '0;
    end else begin
      done_q <= fetch_last;
      if (start_req) begin
        state    <= FS_ISSUE;
        idx      <= '0;
        base_ptr <= rd_ptr;
        seg_q    <= seg;
      end else begin
        case (state)
          FS_ISSUE: if (mem_ready) state <= FS_WAIT;
          FS_WAIT: if (mem_rvalid) begin
            if (idx == LAST_IDX) begin
              state <= FS_IDLE;
            end else begin
              for (int i = 0; i < RRF_FIELDS - 1; i++)
                if (idx == RRF_IDX_W'(i)) fld[i] <= mem_rdata;
              idx   <= idx + 1'b1;
              state <= FS_ISSUE;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/rrf_buf_track.sv
module rrf_buf_track
  import rrf_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              fetch_last,
  input  logic [RRF_FIELDS-1:0][RRF_PW-1:0] entry,
  input  logic                              busy,
  input  logic                              pkt_done,
  input  wide_t                             pkt_words,
  input  ptr_t                              low_thr,
  output wide_t                             buf_addr,
  output wide_t                             buf_words,
  output logic                              low_req
);
  wide_t remaining;
  logic  pkt_take;

  assign remaining = buf_words - pkt_words;
  assign pkt_take  = pkt_done && !busy;
  assign low_req   = pkt_take && below_water(remaining, low_thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_addr  <= '0;
      buf_words <= '0;
    end else if (fetch_last) begin
      buf_addr  <= {entry[1], entry[0]};
      buf_words <= {entry[3], entry[2]};
    end else if (pkt_take) begin
      buf_words <= remaining;
    end
  end
endmodule

// File: rtl/rx_ring_fetch.sv
module rx_ring_fetch
  import rrf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wide,
  input  logic        reg_wr_en,
  input  logic [2:0]  reg_wr_sel,
  input  logic [15:0] reg_wr_data,
  input  logic        cmd_fetch,
  input  logic        exh_clr,
  input  logic        pkt_done,
  input  logic [31:0] pkt_words,
  output logic        mem_valid,
  input  logic        mem_ready,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [15:0] mem_rdata,
  output logic        busy,
  output logic        fetch_done,
  output logic        exhausted,
  output logic [15:0] rd_ptr,
  output logic [31:0] buf_addr,
  output logic [31:0] buf_words
);
  ptr_t ring_start, ring_end, wr_ptr, seg, low_thr, base_ptr, adv_ptr;
  logic fetch_last, adv_hits_wr, low_req, start_req, rd_wr;
  logic [RRF_FIELDS-1:0][RRF_PW-1:0] entry;

  assign rd_wr     = reg_wr_en && (reg_wr_sel == SEL_RD);
  assign start_req = !busy && (cmd_fetch || (exh_clr && exhausted) || low_req);

  rrf_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_sel(reg_wr_sel),
    .wr_data(reg_wr_data), .ring_start(ring_start), .ring_end(ring_end),
    .wr_ptr(wr_ptr), .seg(seg), .low_thr(low_thr)
  );

  rrf_ptr_unit u_ptr (
    .clk(clk), .rst_n(rst_n), .wide(cfg_wide), .rd_wr(rd_wr),
    .rd_wr_data(even_ptr(reg_wr_data)), .fetch_last(fetch_last),
    .base_ptr(base_ptr), .ring_start(ring_start), .ring_end(ring_end),
    .wr_ptr(wr_ptr), .exh_clr(exh_clr), .rd_ptr(rd_ptr),
    .exhausted(exhausted), .adv_ptr(adv_ptr), .adv_hits_wr(adv_hits_wr)
  );

  rrf_fetch_seq u_seq (
    .clk(clk), .rst_n(rst_n), .wide(cfg_wide), .start_req(start_req),
    .rd_ptr(rd_ptr), .seg(seg), .mem_ready(mem_ready),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .busy(busy),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .fetch_last(fetch_last),
    .base_ptr(base_ptr), .entry(entry), .done_q(fetch_done)
  );

  rrf_buf_track u_buf (
    .clk(clk), .rst_n(rst_n), .fetch_last(fetch_last), .entry(entry),
    .busy(busy), .pkt_done(pkt_done), .pkt_words(pkt_words),
    .low_thr(low_thr), .buf_addr(buf_addr), .buf_words(buf_words),
    .low_req(low_req)
  );
endmodule

// File: rtl/rrf_checker.sv
module rrf_checker
  import rrf_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr_en,
  input logic [2:0]  reg_wr_sel,
  input logic        cmd_fetch,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic [31:0] mem_addr,
  input logic        busy,
  input logic        fetch_done,
  input logic        exhausted,
  input logic [15:0] rd_ptr,
  input logic        fetch_last,
  input logic        adv_hits_wr
);
  // R6
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr));

  // R5
  req_in_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> busy);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_last |=> fetch_done && !busy);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |=> !fetch_done);

  // R3
  cmd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && cmd_fetch |=> busy);

  // R4
  busy_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !fetch_last && !(reg_wr_en && reg_wr_sel == SEL_RD) |=> $stable(rd_ptr));

  // R9
  exh_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_last && adv_hits_wr |=> exhausted);
endmodule

bind rx_ring_fetch rrf_checker i_rrf_checker (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
  .cmd_fetch(cmd_fetch), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .busy(busy), .fetch_done(fetch_done),
  .exhausted(exhausted), .rd_ptr(rd_ptr), .fetch_last(fetch_last),
  .adv_hits_wr(adv_hits_wr)
);

// File: tb/test_rx_ring_fetch.sv
module test_rx_ring_fetch;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cfg_wide = 0, reg_wr_en = 0, cmd_fetch = 0, exh_clr = 0, pkt_done = 0;
  logic [2:0]  reg_wr_sel = 0;
  logic [15:0] reg_wr_data = 0;
  logic [31:0] pkt_words = 0;
  logic mem_ready, mem_rvalid;
  logic [15:0] mem_rdata;
  logic mem_valid, busy, fetch_done, exhausted;
  logic [31:0] mem_addr, buf_addr, buf_words;
  logic [15:0] rd_ptr;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_ring_fetch i_rx_ring_fetch (
    .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .reg_wr_en(reg_wr_en),
    .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data), .cmd_fetch(cmd_fetch),
    .exh_clr(exh_clr), .pkt_done(pkt_done), .pkt_words(pkt_words),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .busy(busy),
    .fetch_done(fetch_done), .exhausted(exhausted), .rd_ptr(rd_ptr),
    .buf_addr(buf_addr), .buf_words(buf_words)
  );

  function automatic logic [15:0] mem_f(logic [31:0] a);
    return a[15:0] ^ a[31:16] ^ 16'h3C5A;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory responder: varying ready and latency, one outstanding read
  initial begin
    int cyc = 0, cnt = 0;
    logic pend = 0;
    logic [31:0] raddr = 0;
    mem_ready = 0; mem_rvalid = 0; mem_rdata = 0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_rvalid = 0;
      if (pend) begin
        if (cnt == 0) begin
          mem_rvalid = 1; mem_rdata = mem_f(raddr); pend = 0;
        end else cnt--;
      end
      mem_ready = (cyc % 3) != 1;
      if (mem_valid && mem_ready) begin
        pend = 1; raddr = mem_addr; cnt = cyc % 2;
      end
    end
  end

  // behavioural reference model
  logic        m_busy = 0, m_exh = 0, m_done = 0;
  int          m_phase = 0, m_k = 0;
  logic [15:0] m_f [4];
  logic [15:0] m_rd = 0, m_start = 0, m_end = 0, m_wr = 0, m_seg = 0, m_thr = 0;
  logic [15:0] m_base = 0, m_segq = 0;
  logic [31:0] m_baddr = 0, m_bwords = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_exh = 0; m_done = 0; m_phase = 0; m_k = 0;
      m_rd = 0; m_start = 0; m_end = 0; m_wr = 0; m_seg = 0; m_thr = 0;
      m_base = 0; m_segq = 0; m_baddr = 0; m_bwords = 0;
      for (int i = 0; i < 4; i++) m_f[i] = 0;
    end else begin
      logic [15:0] o_rd, o_seg, adv;
      logic [31:0] rem;
      logic o_busy, o_exh, last, low, go, hitwr;
      o_rd = m_rd; o_seg = m_seg; o_busy = m_busy; o_exh = m_exh;
      last = (m_phase == 2) && mem_rvalid && (m_k == 3);
      rem  = m_bwords - pkt_words;
      low  = pkt_done && !o_busy && (rem < {16'h0, m_thr});
      go   = !o_busy && (cmd_fetch || (exh_clr && o_exh) || low);
      adv  = m_base + (cfg_wide ? 16'd16 : 16'd8);
      if (adv == m_end) adv = m_start;
      hitwr = (adv == m_wr);
      if (reg_wr_en) begin
        case (reg_wr_sel)
          3'd0: m_start = reg_wr_data & 16'hFFFE;
          3'd1: m_end   = reg_wr_data & 16'hFFFE;
          3'd2: if (!last) m_rd = reg_wr_data & 16'hFFFE;
          3'd3: m_wr    = reg_wr_data & 16'hFFFE;
          3'd4: m_seg   = reg_wr_data;
          3'd5: m_thr   = reg_wr_data;
          default: ;
        endcase
      end
      if (exh_clr) m_exh = 0;
      if (last) begin
        m_baddr = {m_f[1], m_f[0]};
        m_bwords = {mem_rdata, m_f[2]};
        m_rd = adv;
        if (hitwr) m_exh = 1;
        m_busy = 0; m_phase = 0;
      end else if (pkt_done && !o_busy) begin
        m_bwords = rem;
      end
      m_done = last;
      if (go) begin
        m_busy = 1; m_phase = 1; m_k = 0; m_base = o_rd; m_segq = o_seg;
      end else if (m_phase == 1 && mem_ready) begin
        m_phase = 2;
      end else if (m_phase == 2 && mem_rvalid && !last) begin
        m_f[m_k] = mem_rdata; m_k++; m_phase = 1;
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3", "busy", 32'(busy), 32'(m_busy));
      chk("R9", "exhausted", 32'(exhausted), 32'(m_exh));
      chk("R8", "rd_ptr", 32'(rd_ptr), 32'(m_rd));
      chk("R7", "buf_addr", buf_addr, m_baddr);
      chk("R10", "buf_words", buf_words, m_bwords);
      chk("R7", "fetch_done", 32'(fetch_done), 32'(m_done));
      chk("R6", "mem_valid", 32'(mem_valid), 32'(m_phase == 1));
      if (m_phase == 1)
        chk("R5", "mem_addr", mem_addr,
            {m_segq, m_base + 16'(m_k * (cfg_wide ? 4 : 2))});
    end
  end

  task automatic wr_reg(input logic [2:0] sel, input logic [15:0] d);
    @(negedge clk); reg_wr_en = 1; reg_wr_sel = sel; reg_wr_data = d;
    @(negedge clk); reg_wr_en = 0;
  endtask

  task automatic pulse_cmd();
    @(negedge clk); cmd_fetch = 1;
    @(negedge clk); cmd_fetch = 0;
  endtask

  task automatic pulse_exh();
    @(negedge clk); exh_clr = 1;
    @(negedge clk); exh_clr = 0;
  endtask

  task automatic pulse_pkt(input logic [31:0] w);
    @(negedge clk); pkt_done = 1; pkt_words = w;
    @(negedge clk); pkt_done = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", 32'(busy), 0);
    chk("R1", "exhausted", 32'(exhausted), 0);
    chk("R1", "mem_valid", 32'(mem_valid), 0);
    chk("R1", "rd_ptr", 32'(rd_ptr), 0);
    chk("R1", "buf_words", buf_words, 0);

    wr_reg(3'd0, 16'h1000);
    wr_reg(3'd1, 16'h1021);
    wr_reg(3'd2, 16'h1001);
    wr_reg(3'd3, 16'h1019);
    wr_reg(3'd4, 16'h0042);
    wr_reg(3'd5, 16'h0010);
    chk("R2", "rd_ptr bit0 cleared", 32'(rd_ptr), 32'h1000);

    pulse_cmd(); wait_idle();
    chk("R8", "rd_ptr after fetch", 32'(rd_ptr), 32'h1008);
    chk("R7", "buf_addr fields", buf_addr,
        {mem_f(32'h0042_1002), mem_f(32'h0042_1000)});
    chk("R7", "buf_words fields", buf_words,
        {mem_f(32'h0042_1006), mem_f(32'h0042_1004)});
    pulse_cmd(); wait_idle();
    pulse_cmd(); wait_idle();
    chk("R9", "exhausted at write pointer", 32'(exhausted), 1);
    pulse_exh(); wait_idle();
    chk("R8", "wrap to start", 32'(rd_ptr), 32'h1000);
    chk("R9", "cleared and refetched", 32'(exhausted), 0);

    // R10 low-water: exactly at threshold, then one below
    w = buf_words - 32'h10;
    pulse_pkt(w);
    chk("R10", "no fetch at threshold", 32'(busy), 0);
    chk("R10", "remaining equals threshold", buf_words, 32'h10);
    pulse_pkt(32'd1);
    chk("R10", "fetch below threshold", 32'(busy), 1);
    wait_idle();
    chk("R10", "rd_ptr after low-water fetch", 32'(rd_ptr), 32'h1008);

    // R4 requests during a fetch are ignored
    pulse_cmd();
    cmd_fetch = 1; pkt_done = 1; pkt_words = 32'd5;
    @(negedge clk); cmd_fetch = 0; pkt_done = 0;
    wait_idle();
    chk("R4", "single advance", 32'(rd_ptr), 32'h1010);
    chk("R4", "pkt ignored while busy", buf_words,
        {mem_f(32'h0042_100E), mem_f(32'h0042_100C)});

    // wide mode
    cfg_wide = 1;
    wr_reg(3'd0, 16'h2000);
    wr_reg(3'd1, 16'h2040);
    wr_reg(3'd2, 16'h2030);
    wr_reg(3'd3, 16'h3000);
    pulse_cmd(); wait_idle();
    chk("R8", "wide wrap", 32'(rd_ptr), 32'h2000);
    chk("R5", "wide field stride", buf_words,
        {mem_f(32'h0042_203C), mem_f(32'h0042_2038)});
    pulse_cmd(); wait_idle();
    chk("R8", "wide advance", 32'(rd_ptr), 32'h2010);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule